// File: doc/BRIEF.md
# Reset-Vectored Accumulator Processor

This block is a very small 8-bit processor built around one accumulator. It has a 16-bit address bus and a single byte-wide read port. When reset is released, it fetches its start address from a vector in the two highest bytes of the address space. It then loops forever: it fetches an opcode, fetches the operand bytes that opcode needs, and performs the operation in a separate execute step.

Four operations are decoded. One loads the accumulator with an immediate byte. One adds an immediate byte to the accumulator and records the carry out. One loads the 16-bit stack pointer from two immediate bytes. One jumps to a 16-bit absolute address. Every other opcode value is a one-byte no-operation, so the core always keeps moving. The memory is synchronous: each byte costs one cycle with the address and strobe driven, then one cycle in which the returned byte is captured. The program counter, accumulator, stack pointer and carry are driven out on ports so the block can be checked from outside.

Top module: `acc_core`

## Requirements
- R1: After reset is released, the first two reads go to address 0xFFFE and then to 0xFFFF. The 0xFFFF read comes two cycles after the 0xFFFE read.
- R2: The start address is big-endian. The byte at 0xFFFE becomes PC[15:8] and the byte at 0xFFFF becomes PC[7:0]. The first opcode read goes to that address.
- R3: Opcode 0x86 is two bytes long. After its execute step, the accumulator holds the byte that follows the opcode, and the carry is unchanged.
- R4: Opcode 0x8B is two bytes long. It sets the accumulator to (accumulator + following byte) mod 256, sets carry to 1 when that sum passes 0xFF and clears it otherwise. Only this opcode changes the carry.
- R5: Opcode 0x8E is three bytes long. It loads the stack pointer with {second byte, third byte}, so the first byte after the opcode is the high half.
- R6: Opcode 0x7E is three bytes long. The next opcode read goes to {second byte, third byte}, high byte first. A jump to its own address repeats forever.
- R7: Any opcode other than 0x86, 0x8B, 0x8E and 0x7E takes one byte, reads no operand, and leaves the accumulator, the stack pointer and the carry unchanged. The next opcode is read from the following address.
- R8: Each byte read drives the strobe high for exactly one cycle, and the next cycle always has the strobe low. Outside jumps, the PC advances by one for each byte read, so the bytes of an instruction, and the next opcode, come from consecutive addresses.
- R9: While rst_n is low, the strobe is low and the accumulator, the stack pointer and the carry read as zero.
- R10: In the cycle in which an opcode read is issued, the visible PC equals the address being read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe; memory returns the byte on the next cycle |
| mem_rdata | input | 8 | Byte returned by memory one cycle after the strobe |
| dbg_pc | output | 16 | Program counter |
| dbg_acc | output | 8 | Accumulator |
| dbg_sp | output | 16 | Stack pointer |
| dbg_carry | output | 1 | Carry from the last add |

## Verification
The assertions check, on every cycle, several timing rules. The strobe is always a single cycle. The 0xFFFF read always comes two cycles after the 0xFFFE read. Each capture of a non-vector byte advances the PC by one. The accumulator, the stack pointer and the carry change only in cycles that follow a cycle without a read. The strobe also stays low during reset. Other behaviour can only be shown by the bench's programs, where a reference model tracks the program. These are the big-endian start address, the values each opcode produces, the carry on add overflow, the carry being kept across loads, the opcodes treated as no-operation, and the jump targets.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_VHI_REQ,
    ST_VHI_CAP,
    ST_VLO_REQ,
    ST_VLO_CAP,
    ST_OP_REQ,
    ST_OP_CAP,
    ST_B1_REQ,
    ST_B1_CAP,
    ST_B2_REQ,
    ST_B2_CAP,
    ST_EXEC
  } cpu_state_e;

  typedef enum logic [2:0] {
    K_NOP,
    K_LDA,
    K_ADD,
    K_LDS,
    K_JMP
  } op_kind_e;

  typedef enum logic [1:0] {
    ASEL_PC,
    ASEL_VHI,
    ASEL_VLO
  } asel_e;

  typedef struct packed {
    logic  rd;
    asel_e asel;
    logic  vhi_we;
    logic  vlo_we;
    logic  op_we;
    logic  b1_we;
    logic  b2_we;
    logic  exec;
  } ctrl_t;

  localparam logic [7:0] OPC_LOAD_ACC = 8'h86;
  localparam logic [7:0] OPC_ADD_ACC  = 8'h8B;
  localparam logic [7:0] OPC_LOAD_SP  = 8'h8E;
  localparam logic [7:0] OPC_JUMP     = 8'h7E;

  function automatic op_kind_e op_decode(input logic [7:0] op);
    case (op)
      OPC_LOAD_ACC: return K_LDA;
      OPC_ADD_ACC:  return K_ADD;
      OPC_LOAD_SP:  return K_LDS;
      OPC_JUMP:     return K_JMP;
      default:      return K_NOP;
    endcase
  endfunction

  function automatic logic needs_two_bytes(input op_kind_e k);
    return (k == K_LDS) || (k == K_JMP);
  endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    sum  = wide[W-1:0];
    cout = wide[W];
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_kind_e fetched_kind,
  input  op_kind_e held_kind,
  output ctrl_t    ctrl
);

  cpu_state_e state_q;
  cpu_state_e state_d;

  // next-state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_BOOT:    state_d = ST_VHI_REQ;
      ST_VHI_REQ: state_d = ST_VHI_CAP;
      ST_VHI_CAP: state_d = ST_VLO_REQ;
      ST_VLO_REQ: state_d = ST_VLO_CAP;
      ST_VLO_CAP: state_d = ST_OP_REQ;
      ST_OP_REQ:  state_d = ST_OP_CAP;
      ST_OP_CAP:  state_d = (fetched_kind == K_NOP) ? ST_OP_REQ : ST_B1_REQ;
      ST_B1_REQ:  state_d = ST_B1_CAP;
      ST_B1_CAP:  state_d = needs_two_bytes(held_kind) ? ST_B2_REQ : ST_EXEC;
      ST_B2_REQ:  state_d = ST_B2_CAP;
      ST_B2_CAP:  state_d = ST_EXEC;
      ST_EXEC:    state_d = ST_OP_REQ;
      default:    state_d = ST_BOOT;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
    end else begin
      state_q <= state_d;
    end
  end

  // control decode
  always_comb begin
    ctrl = '0;
    case (state_q)
      ST_VHI_REQ: begin
        ctrl.rd   = 1'b1;
        ctrl.asel = ASEL_VHI;
      end
      ST_VHI_CAP: ctrl.vhi_we = 1'b1;
      ST_VLO_REQ: begin
        ctrl.rd   = 1'b1;
        ctrl.asel = ASEL_VLO;
      end
      ST_VLO_CAP: ctrl.vlo_we = 1'b1;
      ST_OP_REQ:  ctrl.rd     = 1'b1;
      ST_OP_CAP:  ctrl.op_we  = 1'b1;
      ST_B1_REQ:  ctrl.rd     = 1'b1;
      ST_B1_CAP:  ctrl.b1_we  = 1'b1;
      ST_B2_REQ:  ctrl.rd     = 1'b1;
      ST_B2_CAP:  ctrl.b2_we  = 1'b1;
      ST_EXEC:    ctrl.exec   = 1'b1;
      default:    ctrl        = '0;
    endcase
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] sp,
  output logic              carry,
  output op_kind_e          fetched_kind,
  output op_kind_e          held_kind
);

  localparam logic [ADDR_W-1:0] VEC_LO_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] VEC_HI_ADDR = VEC_LO_ADDR - ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q, pc_d, sp_q, sp_d;
  logic [DATA_W-1:0] acc_q, acc_d, b1_q, b2_q;
  logic              carry_q, carry_d;
  op_kind_e          kind_q;
  logic              pc_en, acc_en, sp_en, carry_en;
  logic [DATA_W-1:0] alu_sum;
  logic              alu_cout;
  logic [ADDR_W-1:0] imm_word;

  acc_alu #(.W(DATA_W)) u_alu (
    .a    (acc_q),
    .b    (b1_q),
    .sum  (alu_sum),
    .cout (alu_cout)
  );

  assign fetched_kind = op_decode(rdata[7:0]);
  assign held_kind    = kind_q;
  assign imm_word     = {b1_q, b2_q};

  // address select
  always_comb begin
    case (ctrl.asel)
      ASEL_VHI: mem_addr = VEC_HI_ADDR;
      ASEL_VLO: mem_addr = VEC_LO_ADDR;
      default:  mem_addr = pc_q;
    endcase
  end

  // next values and clock enables
  always_comb begin
    pc_en    = ctrl.vhi_we | ctrl.vlo_we | ctrl.op_we | ctrl.b1_we | ctrl.b2_we
             | (ctrl.exec & (kind_q == K_JMP));
    pc_d     = pc_q + ADDR_W'(1);
    if (ctrl.vhi_we) begin
      pc_d = {rdata, pc_q[DATA_W-1:0]};
    end else if (ctrl.vlo_we) begin
      pc_d = {pc_q[ADDR_W-1:DATA_W], rdata};
    end else if (ctrl.exec) begin
      pc_d = imm_word;
    end

    acc_en   = ctrl.exec & ((kind_q == K_LDA) | (kind_q == K_ADD));
    acc_d    = (kind_q == K_ADD) ? alu_sum : b1_q;

    carry_en = ctrl.exec & (kind_q == K_ADD);
    carry_d  = alu_cout;

    sp_en    = ctrl.exec & (kind_q == K_LDS);
    sp_d     = imm_word;
  end

  // architectural registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      acc_q   <= '0;
      sp_q    <= '0;
      carry_q <= 1'b0;
    end else begin
      if (pc_en)    pc_q    <= pc_d;
      if (acc_en)   acc_q   <= acc_d;
      if (sp_en)    sp_q    <= sp_d;
      if (carry_en) carry_q <= carry_d;
    end
  end

  // instruction holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_NOP;
      b1_q   <= '0;
      b2_q   <= '0;
    end else begin
      if (ctrl.op_we) kind_q <= fetched_kind;
      if (ctrl.b1_we) b1_q   <= rdata;
      if (ctrl.b2_we) b2_q   <= rdata;
    end
  end

  assign pc    = pc_q;
  assign acc   = acc_q;
  assign sp    = sp_q;
  assign carry = carry_q;

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [DATA_W-1:0] dbg_acc,
  output logic [ADDR_W-1:0] dbg_sp,
  output logic              dbg_carry
);

  ctrl_t    ctrl;
  op_kind_e fetched_kind;
  op_kind_e held_kind;

  acc_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetched_kind (fetched_kind),
    .held_kind    (held_kind),
    .ctrl         (ctrl)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl         (ctrl),
    .rdata        (mem_rdata),
    .mem_addr     (mem_addr),
    .pc           (dbg_pc),
    .acc          (dbg_acc),
    .sp           (dbg_sp),
    .carry        (dbg_carry),
    .fetched_kind (fetched_kind),
    .held_kind    (held_kind)
  );

  assign mem_rd = ctrl.rd;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] dbg_pc,
  input logic [DATA_W-1:0] dbg_acc,
  input logic [ADDR_W-1:0] dbg_sp,
  input logic              dbg_carry
);

  localparam logic [ADDR_W-1:0] VLO = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] VHI = VLO - ADDR_W'(1);

  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  p_vector_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr == VHI) |=> ##1 (mem_rd && mem_addr == VLO));

  p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_rd, 2) && ($past(mem_addr, 2) < VHI)) |-> dbg_pc == $past(dbg_pc) + ADDR_W'(1));

  p_acc_exec_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dbg_acc) |-> !$past(mem_rd));

  p_carry_exec_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dbg_carry) |-> !$past(mem_rd));

  p_sp_exec_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dbg_sp) |-> !$past(mem_rd));

  p_opcode_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd, 2) == 1'b0 && $past(mem_rd) == 1'b0 && mem_addr < VHI) |-> mem_addr == dbg_pc);

  always @(negedge clk) begin
    if (!rst_n) begin
      p_quiet_reset_r9: assert (!mem_rd);
    end
  end

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd),
  .dbg_pc    (dbg_pc),
  .dbg_acc   (dbg_acc),
  .dbg_sp    (dbg_sp),
  .dbg_carry (dbg_carry)
);

// File: tb/test_acc_core.sv
module test_acc_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic [15:0] dbg_pc;
  logic [7:0]  dbg_acc;
  logic [15:0] dbg_sp;
  logic        dbg_carry;

  always #10 clk = ~clk;

  acc_core i_acc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .dbg_pc    (dbg_pc),
    .dbg_acc   (dbg_acc),
    .dbg_sp    (dbg_sp),
    .dbg_carry (dbg_carry)
  );

  // sparse memory: one program page plus the vector bytes
  logic [7:0] prog [0:255];
  logic [7:0] page, vec_lo;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] s_pc, s_sp;
  logic [7:0]  s_acc;
  logic        s_c;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    if (a == 16'hFFFE) return page;
    if (a == 16'hFFFF) return vec_lo;
    if (a[15:8] == page) return prog[a[7:0]];
    return 8'h00;
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_byte(mem_addr);
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual %0d cycles expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // waits for a strobe, snapshots the visible registers, checks the strobe drops
  task automatic fetch(output logic [15:0] a);
    @(negedge clk);
    while (!mem_rd) @(negedge clk);
    a     = mem_addr;
    s_pc  = dbg_pc;
    s_acc = dbg_acc;
    s_sp  = dbg_sp;
    s_c   = dbg_carry;
    @(negedge clk);
    chk(!mem_rd, "R8", "strobe low after read", {31'b0, mem_rd}, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!mem_rd, "R9", "strobe in reset", {31'b0, mem_rd}, 32'h0);
    end
    chk(dbg_acc == 8'h00 && dbg_sp == 16'h0000 && !dbg_carry, "R9", "regs in reset",
        {7'b0, dbg_carry, dbg_acc, dbg_sp}, 32'h0);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] unk();
    case ($urandom % 5)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h3F;
      3: return 8'hA7;
      default: return 8'hC3;
    endcase
  endfunction

  function automatic logic [7:0] imm();
    case ($urandom % 6)
      0: return 8'hFF;
      1: return 8'h01;
      2: return 8'h00;
      default: return 8'($urandom);
    endcase
  endfunction

  // runs the loaded program against a reference model; abort_at < 0 runs to the self loop
  task automatic run_prog(input int abort_at);
    logic [15:0] a, m_pc, tgt;
    logic [15:0] m_sp;
    logic [7:0]  m_acc, op, b1, b2;
    logic [8:0]  sum;
    logic        m_c;
    string       prev;
    int          hits, steps;
    do_reset();
    fetch(a);
    chk(a == 16'hFFFE, "R1", "first read", {16'b0, a}, 32'hFFFE);
    fetch(a);
    chk(a == 16'hFFFF, "R1", "second read", {16'b0, a}, 32'hFFFF);
    m_pc = {page, vec_lo};
    m_acc = 8'h00; m_sp = 16'h0000; m_c = 1'b0;
    prev = "R9"; hits = 0; steps = 0;
    while (hits < 2 && steps < 400 && steps != abort_at) begin
      fetch(a);
      chk(a == m_pc, (steps == 0) ? "R2" : "R8", "opcode address", {16'b0, a}, {16'b0, m_pc});
      chk(s_pc == m_pc, "R10", "visible pc", {16'b0, s_pc}, {16'b0, m_pc});
      chk(s_acc == m_acc, prev, "accumulator", {24'b0, s_acc}, {24'b0, m_acc});
      chk(s_sp == m_sp, prev, "stack pointer", {16'b0, s_sp}, {16'b0, m_sp});
      chk(s_c == m_c, prev, "carry", {31'b0, s_c}, {31'b0, m_c});
      op = mem_byte(m_pc);
      if (op == 8'h86 || op == 8'h8B) begin
        fetch(a);
        chk(a == m_pc + 16'd1, "R8", "operand address", {16'b0, a}, {16'b0, m_pc + 16'd1});
        b1 = mem_byte(m_pc + 16'd1);
        if (op == 8'h86) begin
          m_acc = b1; prev = "R3";
        end else begin
          sum = {1'b0, m_acc} + {1'b0, b1};
          m_acc = sum[7:0]; m_c = sum[8]; prev = "R4";
        end
        m_pc = m_pc + 16'd2;
      end else if (op == 8'h8E || op == 8'h7E) begin
        fetch(a);
        chk(a == m_pc + 16'd1, "R8", "operand high address", {16'b0, a}, {16'b0, m_pc + 16'd1});
        fetch(a);
        chk(a == m_pc + 16'd2, "R8", "operand low address", {16'b0, a}, {16'b0, m_pc + 16'd2});
        b1 = mem_byte(m_pc + 16'd1);
        b2 = mem_byte(m_pc + 16'd2);
        tgt = {b1, b2};
        if (op == 8'h8E) begin
          m_sp = tgt; m_pc = m_pc + 16'd3; prev = "R5";
        end else begin
          if (tgt == m_pc) hits++;
          m_pc = tgt; prev = "R6";
        end
      end else begin
        m_pc = m_pc + 16'd1; prev = "R7";
      end
      steps++;
    end
  endtask

  task automatic gen_random();
    int pos, r, skip;
    page   = 8'h10 + 8'($urandom % 224);
    vec_lo = 8'($urandom % 16);
    for (int i = 0; i < 256; i++) prog[i] = unk();
    pos = int'(vec_lo);
    while (pos < 200) begin
      r = $urandom % 7;
      if (r <= 1) begin
        prog[pos] = 8'h86; prog[pos+1] = imm(); pos += 2;
      end else if (r <= 3) begin
        prog[pos] = 8'h8B; prog[pos+1] = imm(); pos += 2;
      end else if (r == 4) begin
        prog[pos] = 8'h8E; prog[pos+1] = 8'($urandom); prog[pos+2] = 8'($urandom); pos += 3;
      end else if (r == 5) begin
        skip = $urandom % 4;
        prog[pos] = 8'h7E; prog[pos+1] = page; prog[pos+2] = 8'(pos + 3 + skip);
        for (int k = 0; k < skip; k++) prog[pos+3+k] = 8'h8B;
        pos += 3 + skip;
      end else begin
        prog[pos] = unk(); pos += 1;
      end
    end
    prog[pos] = 8'h7E; prog[pos+1] = page; prog[pos+2] = 8'(pos);
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'h1F2E3D4C);
    rst_n = 1'b0;

    // directed: set stack, load 0xFE, add 1, spin (R5 R3 R4 R6)
    page = 8'h80; vec_lo = 8'h00;
    for (int i = 0; i < 256; i++) prog[i] = 8'h00;
    prog[0] = 8'h8E; prog[1] = 8'h01; prog[2] = 8'hFF;
    prog[3] = 8'h86; prog[4] = 8'hFE;
    prog[5] = 8'h8B; prog[6] = 8'h01;
    prog[7] = 8'h7E; prog[8] = 8'h80; prog[9] = 8'h07;
    run_prog(-1);
    chk(dbg_acc == 8'hFF && !dbg_carry, "R4", "0xFE+0x01 result", {23'b0, dbg_carry, dbg_acc}, 32'hFF);
    chk(dbg_sp == 16'h01FF, "R5", "stack pointer load", {16'b0, dbg_sp}, 32'h01FF);

    // directed: big-endian vector with nonzero low byte, carry set/clear/keep (R2 R4 R7)
    page = 8'h12; vec_lo = 8'h34;
    for (int i = 0; i < 256; i++) prog[i] = 8'h00;
    prog[8'h34] = 8'h86; prog[8'h35] = 8'hFF;
    prog[8'h36] = 8'h8B; prog[8'h37] = 8'h01;
    prog[8'h38] = 8'h8B; prog[8'h39] = 8'h00;
    prog[8'h3A] = 8'h8B; prog[8'h3B] = 8'h80;
    prog[8'h3C] = 8'h8B; prog[8'h3D] = 8'h80;
    prog[8'h3E] = 8'h86; prog[8'h3F] = 8'h05;
    prog[8'h40] = 8'h3F;
    prog[8'h41] = 8'h7E; prog[8'h42] = 8'h12; prog[8'h43] = 8'h41;
    run_prog(-1);
    chk(dbg_acc == 8'h05 && dbg_carry, "R4", "carry kept across load", {23'b0, dbg_carry, dbg_acc}, 32'h105);

    // reset in the middle of a program, then rerun it (R9)
    gen_random();
    run_prog(12);
    run_prog(-1);

    for (int n = 0; n < 20; n++) begin
      gen_random();
      run_prog(-1);
    end

    summary();
    $finish;
  end

endmodule